// File: doc/BRIEF.md
# Tiny 8-bit Register-Branch Processor

This block is a small multi-cycle 8-bit processor with four general registers. It has no flags register. Its only conditional control transfer compares two registers and, when the first is lower, jumps to the address held in a third register. Code and data share one byte-addressed memory that sits outside the block on a single-port bus. Reads return data in the same cycle, and a write takes effect at the clock edge while the write enable is high.

Each instruction is one byte. The core fetches it in one cycle and decodes and executes it in the next. A load or store adds a third cycle for the data access. Constants enter only through a 5-bit immediate load, so larger values must be built with add and multiply. Debug outputs expose the program counter and the four registers so that a program's state can be observed.

Top module: `byte_cpu`

## Requirements
- R1: Each instruction is fetched from memory at the address in the program counter in the cycle after the previous instruction completes. A non-memory instruction completes two clock edges after its fetch cycle begins. The program counter starts at 0 after reset, and the first instruction (at address 0) completes at the second edge.
- R2: The program counter holds its value during the fetch and memory cycles. After every instruction except a taken branch, it advances by exactly 1.
- R3: A byte with bit 7 = 0 is an immediate load. Bits 6:5 select the destination register (R0=00, R1=01, R2=10, R3=11), and bits 4:0, zero-extended to 8 bits, are written to it.
- R4: A byte with bits 7:6 = 10 is a compare-branch. Bits 5:4 name register A, bits 3:2 name register B, and bits 1:0 name the target register. If A < B as unsigned values, the program counter takes the target register's value; otherwise it advances by 1.
- R5: A byte with bits 7:4 = 1100 is a load. It takes three clock edges. It writes the memory byte addressed by the register in bits 1:0 into the register in bits 3:2.
- R6: A byte with bits 7:4 = 1101 is a store. It takes three clock edges. It writes the register in bits 3:2 to the memory byte addressed by the register in bits 1:0, and it changes no register.
- R7: A byte with bits 7:4 = 1110 adds the register in bits 1:0 into the register in bits 3:2, keeping the low 8 bits.
- R8: A byte with bits 7:4 = 1111 multiplies the register in bits 3:2 by the register in bits 1:0 and writes the low 8 bits of the product to the register in bits 3:2.
- R9: A synchronous reset sets the program counter and all four registers to 0 and drops the write enable, including when it is asserted while a program is running.
- R10: Data and code may be placed together in one memory. A 5-byte vector 1,2,3,4,5 at address 0, followed by the looping increment program at address 5, leaves the vector as 2,2,3,4,5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for a fetch or a data access |
| mem_wdata | output | 8 | Data to write to memory |
| mem_rdata | input | 8 | Memory read data for mem_addr, same cycle |
| mem_we | output | 1 | Memory write enable, written at the clock edge |
| dbg_pc | output | 8 | Current program counter |
| dbg_regs | output | 32 | Registers packed as {R3, R2, R1, R0} |

## Verification
The assertions check the following on every cycle:
- fetches use the program counter as the address and never write;
- the counter stays still during a fetch;
- reset clears the state;
- an immediate load writes its zero-extended field;
- a compare-branch lands on its target or on the next address;
- additions wrap;
- a store advances the counter and leaves the registers untouched.

Only the bench's programs can show the behaviours that depend on whole instruction sequences:
- the exact cycle counts of loads;
- multiply overflow over chains of operations;
- unsigned comparison of values at or above 128, built by multiplication;
- code running through a data vector placed at address 0;
- the final memory image of the looping program.

// File: rtl/byte_cpu.sv
module byte_cpu (
  input  logic        clk,
  input  logic        rst,
  output logic [7:0]  mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [7:0]  dbg_pc,
  output logic [31:0] dbg_regs
);

  localparam int W  = 8;
  localparam int NR = 4;

  typedef enum logic [1:0] {PH_FETCH = 2'd0, PH_EXEC = 2'd1, PH_MEM = 2'd2} phase_t;

  phase_t       phase;
  logic [W-1:0] pc, ir;
  logic [W-1:0] rf [NR];

  wire [1:0]   mov_rd = ir[6:5];
  wire [W-1:0] mov_v  = {3'b000, ir[4:0]};
  wire [1:0]   cmp_a  = ir[5:4];
  wire [1:0]   cmp_b  = ir[3:2];
  wire [1:0]   cmp_t  = ir[1:0];
  wire [1:0]   op_x   = ir[3:2];
  wire [1:0]   op_y   = ir[1:0];
  wire         is_mov = ~ir[7];
  wire         is_blt = ir[7:6] == 2'b10;
  wire         is_mem = ir[7:5] == 3'b110;
  wire         is_st  = ir[4];
  wire         is_mul = ir[4];
  wire [W-1:0] pc_inc = pc + 8'd1;
  wire         lower  = rf[cmp_a] < rf[cmp_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= '0;
      ir    <= '0;
      for (int i = 0; i < NR; i++) rf[i] <= '0;
    end else begin
      case (phase)
        PH_FETCH: begin
          ir    <= mem_rdata;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          phase <= PH_FETCH;
          if (is_mov) begin
            rf[mov_rd] <= mov_v;
            pc         <= pc_inc;
          end else if (is_blt) begin
            pc <= lower ? rf[cmp_t] : pc_inc;
          end else if (is_mem) begin
            phase <= PH_MEM;
          end else begin
            rf[op_x] <= is_mul ? rf[op_x] * rf[op_y] : rf[op_x] + rf[op_y];
            pc       <= pc_inc;
          end
        end
        PH_MEM: begin
          if (!is_st) rf[op_x] <= mem_rdata;
          pc    <= pc_inc;
          phase <= PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign mem_addr  = (phase == PH_MEM) ? rf[op_y] : pc;
  assign mem_wdata = rf[op_x];
  assign mem_we    = (phase == PH_MEM) && is_st;
  assign dbg_pc    = pc;
  assign dbg_regs  = {rf[3], rf[2], rf[1], rf[0]};

endmodule

// File: rtl/byte_cpu_chk.sv
module byte_cpu_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  phase,
  input logic [7:0]  ir,
  input logic [7:0]  mem_addr,
  input logic        mem_we,
  input logic [7:0]  dbg_pc,
  input logic [31:0] dbg_regs
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  function automatic logic [7:0] rsel(input logic [31:0] r, input logic [1:0] i);
    return r[{i, 3'b000} +: 8];
  endfunction

  wire       in_fetch = phase == 2'd0;
  wire       in_exec  = phase == 2'd1;
  wire [7:0] ra = rsel(dbg_regs, ir[5:4]);
  wire [7:0] rb = rsel(dbg_regs, ir[3:2]);
  wire [7:0] rc = rsel(dbg_regs, ir[1:0]);

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    in_fetch |-> (mem_addr == dbg_pc) && !mem_we); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_fetch) |-> $stable(dbg_pc)); // R2

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbg_pc == 8'd0) && (dbg_regs == 32'd0) && !mem_we); // R9

  AST_MOV_IMM: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_exec && !ir[7]) |->
      rsel(dbg_regs, $past(ir[6:5])) == {3'b000, $past(ir[4:0])}); // R3

  AST_BLT_TARGET: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_exec && ir[7:6] == 2'b10) |->
      dbg_pc == ($past(ra < rb) ? $past(rc) : $past(dbg_pc) + 8'd1)); // R4

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(in_exec && ir[7:4] == 4'b1110) |->
      rsel(dbg_regs, $past(ir[3:2])) == 8'($past(rb) + $past(rc))); // R7

  AST_ST_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(dbg_regs) && (dbg_pc == $past(dbg_pc) + 8'd1)); // R6

endmodule

bind byte_cpu byte_cpu_chk chk_i (
  .clk(clk), .rst(rst), .phase(phase), .ir(ir), .mem_addr(mem_addr),
  .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
);

// File: tb/byte_cpu_tb_top.sv
`timescale 1ns/1ps
module byte_cpu_tb_top;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  dbg_pc;
  logic [31:0] dbg_regs;
  logic [7:0]  mem [256];

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  byte_cpu dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return dbg_regs[i*8 +: 8];
  endfunction

  function automatic logic [7:0] f_mov(input int rd, input logic [4:0] v);
    return {1'b0, 2'(rd), v};
  endfunction

  function automatic logic [7:0] exp_sq(input logic [4:0] x, input logic [4:0] y);
    logic [7:0] p;
    p = 8'(x * y);
    return 8'(p * p);
  endfunction

  function automatic logic [7:0] exp_flag(input logic [4:0] a, input logic [4:0] b,
                                          input logic [4:0] c, input logic [4:0] d);
    logic [7:0] l, r;
    l = 8'(a * b);
    r = 8'(c * d);
    return (l < r) ? 8'd2 : 8'd1;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic reset_cpu();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic run_to(input logic [7:0] halt, output bit ok);
    ok = 0;
    for (int c = 0; c < 2000 && !ok; c++) begin
      @(negedge clk);
      if (dbg_pc == halt) ok = 1;
    end
  endtask

  task automatic alu_test(input logic [4:0] x, input logic [4:0] y);
    bit ok;
    clear_mem();
    mem[0]  = f_mov(0, x);
    mem[1]  = f_mov(1, y);
    mem[2]  = f_mov(2, x);
    mem[3]  = 8'hE1;
    mem[4]  = 8'hF9;
    mem[5]  = 8'h7E;
    mem[6]  = 8'hD3;
    mem[7]  = 8'hFA;
    mem[8]  = 8'h7F;
    mem[9]  = 8'hDB;
    mem[10] = 8'h20;
    mem[11] = 8'h61;
    mem[12] = 8'h0D;
    mem[13] = 8'h9C;
    reset_cpu();
    run_to(8'd13, ok);
    chk("R2 halt reached", 32'(ok), 32'd1);
    chk("R7 add stored", 32'(mem[30]), 32'(8'(x + y)));
    chk("R8 mul wrap stored", 32'(mem[31]), 32'(exp_sq(x, y)));
    chk("R8 mul reg", 32'(reg_of(2)), 32'(exp_sq(x, y)));
    chk("R3 imm regs", {16'd0, reg_of(1), reg_of(3)}, {16'd0, 8'd0, 8'd1});
    chk("R6 store target only", 32'(mem[29]), 32'd0);
  endtask

  task automatic blt_test(input logic [4:0] a, input logic [4:0] b,
                          input logic [4:0] c, input logic [4:0] d);
    bit ok;
    clear_mem();
    mem[0]  = 8'h62;
    mem[1]  = f_mov(0, a);
    mem[2]  = f_mov(1, b);
    mem[3]  = 8'hF1;
    mem[4]  = f_mov(1, c);
    mem[5]  = f_mov(2, d);
    mem[6]  = 8'hF6;
    mem[7]  = f_mov(2, 5'd10);
    mem[8]  = 8'h86;
    mem[9]  = 8'h61;
    mem[10] = f_mov(2, 5'd29);
    mem[11] = 8'hDE;
    mem[12] = 8'h20;
    mem[13] = 8'h41;
    mem[14] = 8'h0F;
    mem[15] = 8'h98;
    reset_cpu();
    run_to(8'd15, ok);
    chk("R4 blt halt reached", 32'(ok), 32'd1);
    chk("R4 unsigned compare", 32'(mem[29]), 32'(exp_flag(a, b, c, d)));
  endtask

  task automatic vector_test();
    bit ok;
    logic [7:0] img [18];
    img = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00, 8'h21, 8'h63, 8'hC8,
            8'hE9, 8'hD8, 8'hE1, 8'h48, 8'hEB, 8'h8E, 8'h51, 8'h00, 8'h86};
    clear_mem();
    for (int i = 0; i < 18; i++) mem[i] = img[i];
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R9 reset pc", 32'(dbg_pc), 32'd0);
    chk("R9 reset regs", dbg_regs, 32'd0);
    chk("R9 reset we", 32'(mem_we), 32'd0);
    rst = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R1 first instr 2 edges", 32'(dbg_pc), 32'd1);
    chk("R3 vector byte as mov", 32'(reg_of(0)), 32'd1);
    repeat (15) @(posedge clk); @(negedge clk);
    chk("R2 pc holds in fetch", 32'(dbg_pc), 32'd8);
    @(posedge clk); @(negedge clk);
    chk("R5 pc holds before mem", 32'(dbg_pc), 32'd8);
    @(posedge clk); @(negedge clk);
    chk("R5 load 3 edges", 32'(dbg_pc), 32'd9);
    chk("R5 load data", 32'(reg_of(2)), 32'd1);
    run_to(8'h11, ok);
    chk("R10 halt reached", 32'(ok), 32'd1);
    chk("R10 vector", {mem[0], mem[1], mem[2], mem[3]}, 32'h02020304);
    chk("R10 vector tail", 32'(mem[4]), 32'd5);
    chk("R6 final regs", dbg_regs, {8'd3, 8'h11, 8'd1, 8'd0});
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R9 mid-run reset", {dbg_pc, 24'd0} | 32'(dbg_regs != 0), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    vector_test();
    alu_test(5'd31, 5'd31);
    alu_test(5'd0, 5'd17);
    blt_test(5'd16, 5'd8, 5'd16, 5'd8);
    blt_test(5'd16, 5'd9, 5'd31, 5'd31);
    blt_test(5'd1, 5'd0, 5'd0, 5'd1);
    for (int k = 0; k < 20; k++) begin
      alu_test(5'($urandom), 5'($urandom));
      blt_test(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule